// File: doc/BRIEF.md
# PRBS Generator with Zero-Run and Density Shaping

This block produces one pseudo-random bit per clock from a selectable maximal-length linear feedback shift register. Six sequence orders are available. Two optional shapers sit on the raw sequence. A mark-density shaper combines neighbouring register bits to set the share of ones. A zero-run shaper forces a programmable number of zeros at the start of every repetition and then forces a one, so the longest zero run can be stretched far beyond the natural n-1.

A trigger output serves external instruments in one of two ways. In pattern mode it pulses on the first bit of every fourth repetition. In divided mode it is a square wave at the clock rate divided by a selectable ratio.

The reset is synchronous and active low. The register always reloads its nonzero seed on reset and whenever the polynomial selection changes, so it can never lock up in the all-zero state.

Top module: `prbs_dgen`

## Requirements
- R1: `poly_sel` codes 0..5 select orders 7, 10, 11, 15, 23, 31, with feedback taps (7,6), (10,7), (11,9), (15,14), (23,18), (31,28). Codes 6 and 7 select order 7. With density code 0 and `zlen` 0, `data_out` repeats with period 2^n-1 and carries 2^(n-1) ones per period.
- R2: While `rst_n` is low, `data_out` and `trig_out` are 0. The first bit after reset is the start of a repetition, which opens with n-1 zeros followed by a one.
- R3: In the clock where `poly_sel` first differs from its value in the previous clock, the next `data_out` bit is 0 and no pattern pulse is emitted. The bit after that starts the new sequence from its seed.
- R4: `dens_sel` sets the share of ones: 0 gives 1/2, 1 gives 1/4, 2 gives 1/8, 3 gives 3/4, and 4 gives 7/8. Codes 5..7 give 1/2. For order 7 without zero-run shaping, a period holds exactly 64, 32, 16, 96 and 112 ones respectively.
- R5: If `zlen` >= n, each repetition begins with L = min(`zlen`, 2^n-2) zeros followed by a forced one. If `zlen` < n, the sequence is unchanged. No zero run ever reaches 2^n bits.
- R6: With `trig_mode` = 0, `trig_out` is a one-clock pulse on the first bit of the 1st, 5th, 9th, ... repetition after reset or after a polynomial reload.
- R7: With `trig_mode` = 1, `trig_out` is a square wave. `div_sel` codes 0..8 give ratios 2, 4, 8, 10, 16, 20, 32, 64, 128, and other codes give 2. For a ratio D, the output is high for floor(D/2) clocks and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poly_sel | input | 3 | Sequence order select |
| zlen | input | ZLEN_W | Forced zero-run length |
| dens_sel | input | 3 | Ones density select |
| trig_mode | input | 1 | 0: pattern pulse, 1: divided clock |
| div_sel | input | 4 | Divided-clock ratio select |
| data_out | output | 1 | Serial data bit |
| trig_out | output | 1 | Trigger output |

## Verification
The bench builds the block with its defaults: a trigger every four repetitions, a 31-bit run length, and density shaping enabled. With these values, full order-7 periods are short enough that several four-repetition trigger intervals and the 2^n-2 clamp of the zero run fit in a short run. Orders 10 and 11 fit two whole periods each, which allows a direct period comparison. Order 31 exercises only its seed run, its shaping and its reload behaviour, since a full period is far out of reach.

// File: rtl/prbs_dgen_pkg.sv
`timescale 1ns/1ps
package prbs_dgen_pkg;

   localparam int LFSR_W = 31;

   // sequence order for a selection code
   function automatic logic [4:0] poly_order(input logic [2:0] sel);
      case (sel)
         3'd1:    return 5'd10;
         3'd2:    return 5'd11;
         3'd3:    return 5'd15;
         3'd4:    return 5'd23;
         3'd5:    return 5'd31;
         default: return 5'd7;
      endcase
   endfunction

   // second feedback tap for a selection code
   function automatic logic [4:0] poly_tap(input logic [2:0] sel);
      case (sel)
         3'd1:    return 5'd7;
         3'd2:    return 5'd9;
         3'd3:    return 5'd14;
         3'd4:    return 5'd18;
         3'd5:    return 5'd28;
         default: return 5'd6;
      endcase
   endfunction

   // divided-clock ratio for a selection code
   function automatic logic [7:0] div_ratio(input logic [3:0] sel);
      case (sel)
         4'd1:    return 8'd4;
         4'd2:    return 8'd8;
         4'd3:    return 8'd10;
         4'd4:    return 8'd16;
         4'd5:    return 8'd20;
         4'd6:    return 8'd32;
         4'd7:    return 8'd64;
         4'd8:    return 8'd128;
         default: return 8'd2;
      endcase
   endfunction

endpackage

// File: rtl/prbs_dgen_lfsr.sv
`timescale 1ns/1ps
module prbs_dgen_lfsr
   import prbs_dgen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] poly_sel,
   output logic       start,
   output logic       reload,
   output logic [2:0] head,
   output logic [4:0] order
);
   localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

   logic [LFSR_W-1:0] st, st_nx, mask;
   logic [2:0]        sel_q;
   logic [4:0]        tap;
   logic              fb;

   always_comb begin
      order = poly_order(sel_q);
      tap   = poly_tap(sel_q);
      for (int i = 0; i < LFSR_W; i++) begin
         mask[i] = (5'(i) < order);
      end
      fb     = st[order - 5'd1] ^ st[tap - 5'd1];
      st_nx  = {st[LFSR_W-2:0], fb} & mask;
      head   = {st[order - 5'd1], st[order - 5'd2], st[order - 5'd3]};
      start  = (st == SEED);
      reload = (poly_sel != sel_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || reload) begin
         st    <= SEED;
         sel_q <= poly_sel;
      end else begin
         st    <= st_nx;
      end
   end
endmodule

// File: rtl/prbs_dgen_shaper.sv
`timescale 1ns/1ps
module prbs_dgen_shaper #(
   parameter int ZLEN_W  = 31,
   parameter bit DENS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              reload,
   input  logic [2:0]        head,
   input  logic [4:0]        order,
   input  logic [2:0]        dens_sel,
   input  logic [ZLEN_W-1:0] zlen,
   output logic              data_out
);
   logic [31:0] span, zl_ext, zl_eff, zcnt;
   logic        zact, zen, zload, dbit, bit_nx;

   generate
      if (DENS_EN) begin : g_dens
         always_comb begin
            case (dens_sel)
               3'd1:    dbit = head[2] & head[1];
               3'd2:    dbit = &head;
               3'd3:    dbit = head[2] | head[1];
               3'd4:    dbit = |head;
               default: dbit = head[2];
            endcase
         end
      end else begin : g_raw
         assign dbit = head[2];
      end
   endgenerate

   always_comb begin
      span   = (32'd1 << order) - 32'd2;
      zl_ext = 32'(zlen);
      zl_eff = (zl_ext > span) ? span : zl_ext;
      zen    = (zl_eff >= {27'd0, order});
      zload  = start && zen;
      if (zload)      bit_nx = 1'b0;
      else if (zact)  bit_nx = (zcnt == 32'd0);
      else            bit_nx = dbit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || reload) begin
         data_out <= 1'b0;
         zact     <= 1'b0;
         zcnt     <= 32'd0;
      end else begin
         data_out <= bit_nx;
         if (zload) begin
            zact <= 1'b1;
            zcnt <= zl_eff - 32'd1;
         end else if (zact) begin
            if (zcnt == 32'd0) zact <= 1'b0;
            else               zcnt <= zcnt - 32'd1;
         end
      end
   end
endmodule

// File: rtl/prbs_dgen_trig.sv
`timescale 1ns/1ps
module prbs_dgen_trig
   import prbs_dgen_pkg::*;
#(
   parameter int REPS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       reload,
   input  logic       trig_mode,
   input  logic [3:0] div_sel,
   output logic       trig_out
);
   localparam int RW = (REPS > 1) ? $clog2(REPS) : 1;

   logic [RW-1:0] rep;
   logic [3:0]    dsel_q;
   logic [7:0]    dcnt, dlen, dhalf;
   logic          sq, pulse;

   always_comb begin
      dlen  = div_ratio(dsel_q);
      dhalf = {1'b0, dlen[7:1]};
      sq    = (dcnt < dhalf);
      pulse = start && !reload && (rep == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rep      <= '0;
         dsel_q   <= div_sel;
         dcnt     <= 8'd0;
         trig_out <= 1'b0;
      end else begin
         if (reload)                      rep <= '0;
         else if (start && rep == RW'(REPS-1)) rep <= '0;
         else if (start)                  rep <= rep + RW'(1);
         if (div_sel != dsel_q) begin
            dsel_q <= div_sel;
            dcnt   <= 8'd0;
         end else begin
            dcnt   <= (dcnt == dlen - 8'd1) ? 8'd0 : dcnt + 8'd1;
         end
         trig_out <= trig_mode ? sq : pulse;
      end
   end
endmodule

// File: rtl/prbs_dgen.sv
`timescale 1ns/1ps
module prbs_dgen #(
   parameter int REPS    = 4,
   parameter int ZLEN_W  = 31,
   parameter bit DENS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        poly_sel,
   input  logic [ZLEN_W-1:0] zlen,
   input  logic [2:0]        dens_sel,
   input  logic              trig_mode,
   input  logic [3:0]        div_sel,
   output logic              data_out,
   output logic              trig_out
);
   generate
      if (REPS < 2) begin : g_bad_reps
         $error("REPS must be 2 or more");
      end
      if (ZLEN_W < 5 || ZLEN_W > 31) begin : g_bad_zlen
         $error("ZLEN_W must lie in 5..31");
      end
   endgenerate

   logic       start, reload;
   logic [2:0] head;
   logic [4:0] order;

   prbs_dgen_lfsr u_lfsr (
      .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel),
      .start(start), .reload(reload), .head(head), .order(order)
   );

   prbs_dgen_shaper #(.ZLEN_W(ZLEN_W), .DENS_EN(DENS_EN)) u_shape (
      .clk(clk), .rst_n(rst_n), .start(start), .reload(reload),
      .head(head), .order(order), .dens_sel(dens_sel), .zlen(zlen),
      .data_out(data_out)
   );

   prbs_dgen_trig #(.REPS(REPS)) u_trig (
      .clk(clk), .rst_n(rst_n), .start(start), .reload(reload),
      .trig_mode(trig_mode), .div_sel(div_sel), .trig_out(trig_out)
   );
endmodule

// File: rtl/prbs_dgen_chk.sv
`timescale 1ns/1ps
module prbs_dgen_chk
   import prbs_dgen_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] poly_sel,
   input logic       trig_mode,
   input logic       data_out,
   input logic       trig_out
);
   logic [2:0]  psel_q;
   logic [31:0] zrun, zbound;

   always_ff @(posedge clk) begin
      if (!rst_n || poly_sel != psel_q) begin
         psel_q <= poly_sel;
         zrun   <= 32'd0;
      end else begin
         zrun   <= data_out ? 32'd0 : zrun + 32'd1;
      end
   end

   assign zbound = 32'd1 << poly_order(psel_q);

   // R2: outputs are quiet in the first clock after reset
   p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (data_out == 1'b0 && trig_out == 1'b0));

   // R3: a new polynomial selection yields one zero bit
   p_reload_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (poly_sel != $past(poly_sel)) |=> (data_out == 1'b0));

   // R6: pattern pulse lasts exactly one clock
   p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode && !$past(trig_mode) && trig_out) |=> !trig_out);

   // R5: no zero run reaches 2^n bits
   p_zero_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      zrun < zbound);
endmodule

bind prbs_dgen prbs_dgen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .trig_mode(trig_mode),
   .data_out(data_out), .trig_out(trig_out)
);

// File: tb/sim_prbs_dgen.sv
`timescale 1ns/1ps
module sim_prbs_dgen;
   localparam real HALF = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  poly_sel = 3'd0;
   logic [30:0] zlen = 31'd0;
   logic [2:0]  dens_sel = 3'd0;
   logic        trig_mode = 1'b0;
   logic [3:0]  div_sel = 4'd0;
   logic        data_out, trig_out;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [30:0] m_st;
   logic [2:0]  m_sel;
   logic        m_zact;
   logic [31:0] m_zcnt;
   int          m_rep;
   logic        exp_d, exp_t;
   string       cur_tag;
   logic        bits [0:4199];

   always #(HALF) clk = ~clk;

   prbs_dgen u0 (
      .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .zlen(zlen),
      .dens_sel(dens_sel), .trig_mode(trig_mode), .div_sel(div_sel),
      .data_out(data_out), .trig_out(trig_out)
   );

   function automatic int ord_of(input logic [2:0] s);
      case (s) 3'd1: return 10; 3'd2: return 11; 3'd3: return 15;
               3'd4: return 23; 3'd5: return 31; default: return 7; endcase
   endfunction

   function automatic int tap_of(input logic [2:0] s);
      case (s) 3'd1: return 7; 3'd2: return 9; 3'd3: return 14;
               3'd4: return 18; 3'd5: return 28; default: return 6; endcase
   endfunction

   function automatic int ratio_of(input logic [3:0] s);
      case (s) 4'd1: return 4; 4'd2: return 8; 4'd3: return 10; 4'd4: return 16;
               4'd5: return 20; 4'd6: return 32; 4'd7: return 64; 4'd8: return 128;
               default: return 2; endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_step();
      int n, t;
      logic b2, b1, b0, dbit, fb, st0;
      logic [31:0] span, zl;
      if (!rst_n || poly_sel != m_sel) begin
         m_st = 31'd1; m_sel = poly_sel; m_zact = 1'b0; m_zcnt = 32'd0;
         m_rep = 0; exp_d = 1'b0; exp_t = 1'b0;
      end else begin
         n = ord_of(m_sel); t = tap_of(m_sel);
         b2 = m_st[n-1]; b1 = m_st[n-2]; b0 = m_st[n-3];
         case (dens_sel)
            3'd1: dbit = b2 & b1;
            3'd2: dbit = b2 & b1 & b0;
            3'd3: dbit = b2 | b1;
            3'd4: dbit = b2 | b1 | b0;
            default: dbit = b2;
         endcase
         span = (32'd1 << n) - 32'd2;
         zl = {1'b0, zlen};
         if (zl > span) zl = span;
         st0 = (m_st == 31'd1);
         if (st0 && zl >= 32'(n)) begin
            exp_d = 1'b0; m_zact = 1'b1; m_zcnt = zl - 32'd1;
         end else if (m_zact) begin
            exp_d = (m_zcnt == 32'd0);
            if (m_zcnt == 32'd0) m_zact = 1'b0; else m_zcnt = m_zcnt - 32'd1;
         end else begin
            exp_d = dbit;
         end
         exp_t = st0 && (m_rep == 0);
         if (st0) m_rep = (m_rep + 1) % 4;
         fb = m_st[n-1] ^ m_st[t-1];
         m_st = {m_st[29:0], fb} & (31'h7fffffff >> (31 - n));
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk({cur_tag, " data"}, int'(data_out), int'(exp_d));
      if (!trig_mode) chk({cur_tag, " trig"}, int'(trig_out), int'(exp_t));
   endtask

   task automatic do_reset(input logic [2:0] p, input logic [2:0] d,
                           input logic [30:0] z, input logic m, input logic [3:0] dv);
      poly_sel = p; dens_sel = d; zlen = z; trig_mode = m; div_sel = dv;
      rst_n = 1'b0;
      cur_tag = "R2 reset";
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   initial begin
      #(HALF * 2.0 * 190000.0);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));

      // R1, R2: every order, seed run, period and ones count
      for (int p = 0; p < 7; p++) begin
         int n, per, len, ok, ones;
         do_reset(3'(p), 3'd0, 31'd0, 1'b0, 4'd0);
         n = ord_of(3'(p)); per = (1 << n) - 1;
         len = (n <= 11) ? 2 * per : 300;
         cur_tag = "R1 sequence";
         for (int i = 0; i < len; i++) begin tick(); bits[i] = data_out; end
         ok = 1;
         for (int i = 0; i < n - 1; i++) if (bits[i] != 1'b0) ok = 0;
         if (bits[n-1] != 1'b1) ok = 0;
         chk("R2 seed run", ok, 1);
         if (n <= 11) begin
            ok = 1; ones = 0;
            for (int i = 0; i < per; i++) begin
               if (bits[i] != bits[i+per]) ok = 0;
               if (bits[i]) ones++;
            end
            chk("R1 period", ok, 1);
            chk("R1 ones per period", ones, 1 << (n - 1));
         end
      end

      // R4: density on order 7
      for (int d = 0; d < 6; d++) begin
         int ones, expv;
         do_reset(3'd0, 3'(d), 31'd0, 1'b0, 4'd0);
         cur_tag = "R4 density";
         ones = 0;
         for (int i = 0; i < 127; i++) begin tick(); if (data_out) ones++; end
         case (d) 1: expv = 32; 2: expv = 16; 3: expv = 96; 4: expv = 112; default: expv = 64; endcase
         chk("R4 ones count", ones, expv);
      end

      // R5: zero-run substitution including clamp and below-order cases
      for (int c = 0; c < 6; c++) begin
         logic [2:0] p; logic [30:0] z; int expz, zc, guard;
         case (c)
            0: begin p = 3'd0; z = 31'd20;   expz = 20;   end
            1: begin p = 3'd0; z = 31'd5;    expz = 6;    end
            2: begin p = 3'd0; z = 31'd7;    expz = 7;    end
            3: begin p = 3'd0; z = 31'd1000; expz = 126;  end
            4: begin p = 3'd5; z = 31'd40;   expz = 40;   end
            default: begin p = 3'd1; z = 31'd1022; expz = 1022; end
         endcase
         do_reset(p, 3'd0, z, 1'b0, 4'd0);
         cur_tag = "R5 zero run";
         zc = 0; guard = 0;
         tick();
         while (!data_out && guard < 1100) begin zc++; guard++; tick(); end
         chk("R5 leading zeros", zc, expz);
         chk("R5 forced one", int'(data_out), 1);
         if (c == 3) begin
            zc = 0; guard = 0;
            tick();
            while (!data_out && guard < 300) begin zc++; guard++; tick(); end
            chk("R5 clamp second period", zc, 126);
         end
      end

      // R3: polynomial change mid-run
      do_reset(3'd0, 3'd0, 31'd0, 1'b0, 4'd0);
      cur_tag = "R3 before change";
      repeat (50) tick();
      poly_sel = 3'd1;
      cur_tag = "R3 reload";
      tick();
      chk("R3 reload bit", int'(data_out), 0);
      chk("R3 reload no pulse", int'(trig_out), 0);
      begin
         int zc, firstpulse;
         tick(); firstpulse = trig_out; zc = 0;
         while (!data_out && zc < 20) begin zc++; tick(); end
         chk("R3 new seed run", zc, 9);
         chk("R3 R6 pulse on new start", firstpulse, 1);
      end

      // R6: pattern trigger every fourth repetition
      begin
         int cnt, pos0, pos1;
         do_reset(3'd0, 3'd0, 31'd0, 1'b0, 4'd0);
         cur_tag = "R6 pattern trig";
         cnt = 0; pos0 = -1; pos1 = -1;
         for (int i = 0; i < 1020; i++) begin
            tick();
            if (trig_out) begin
               if (cnt == 0) pos0 = i; else if (cnt == 1) pos1 = i;
               cnt++;
            end
         end
         chk("R6 pulse count", cnt, 3);
         chk("R6 first pulse", pos0, 0);
         chk("R6 second pulse", pos1, 508);
      end

      // R7: divided clock ratios
      for (int c = 0; c < 10; c++) begin
         logic [3:0] code; int dv, hi, lo, g; logic prev;
         code = (c == 9) ? 4'd12 : 4'(c);
         dv = ratio_of(code);
         do_reset(3'd0, 3'd0, 31'd0, 1'b1, code);
         cur_tag = "R7 divider";
         repeat (3) tick();
         prev = trig_out; tick(); g = 0;
         while (!(!prev && trig_out) && g < 300) begin prev = trig_out; tick(); g++; end
         hi = 1; g = 0;
         tick();
         while (trig_out && g < 300) begin hi++; g++; tick(); end
         lo = 1; g = 0;
         tick();
         while (!trig_out && g < 300) begin lo++; g++; tick(); end
         chk("R7 high time", hi, dv / 2);
         chk("R7 low time", lo, dv - dv / 2);
      end

      // R1 R4 R5 R6: constrained random segments against the model
      for (int s = 0; s < 20; s++) begin
         logic [2:0] p, d; logic [30:0] z; int r;
         p = 3'($urandom % 8); d = 3'($urandom % 8); r = int'($urandom % 4);
         case (r)
            0: z = 31'd0;
            1: z = 31'($urandom % 12);
            2: z = 31'($urandom % 300);
            default: z = 31'($urandom);
         endcase
         do_reset(p, d, z, 1'b0, 4'd0);
         cur_tag = "R1 R4 R5 R6 random";
         for (int i = 0; i < 300; i++) begin
            if (i == 150 && ($urandom % 3) == 0) poly_sel = 3'($urandom % 8);
            tick();
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule